// File: doc/BRIEF.md
# Configurable PWM Dead-Band Generator

This block sits between a PWM action stage and the gate drivers. It takes two PWM signals, A and B, and produces two outputs with dead time inserted. Two delay paths run side by side. One path holds back rising edges and lets falling edges through at once. The other path holds back falling edges and lets rising edges through at once. Each path is timed by its own counter with its own programmable length.

Three small configuration fields shape the block:
- The source select picks whether each path listens to A or to B.
- The polarity field inverts either delayed signal on its own.
- The output mode picks, per output, the delayed path or the raw input. Output A uses the rising-edge path and output B uses the falling-edge path.

With both paths fed from A, the polarity settings give the usual gate-driver styles: active-high, active-low, and the two complementary forms. With bypass selected, the block drops out of the signal path.

Top module: `pwm_deadband`

## Requirements
- R1: With output-mode bit 1 set, a rising edge on the rising-path source reaches out_a exactly `dly_rise` cycles later than with `dly_rise` = 0. A falling edge on that source reaches out_a with no added delay.
- R2: With output-mode bit 0 set, a falling edge on the falling-path source reaches out_b exactly `dly_fall` cycles later than with `dly_fall` = 0. A rising edge on that source reaches out_b with no added delay.
- R3: If a path's source returns to its former level before that path's count completes, the count is dropped and the delayed output shows no pulse.
- R4: `cfg_src` selects the path sources. Bit 0 picks the rising-path source and bit 1 picks the falling-path source; 0 means A and 1 means B. Codes 00, 01, 10 and 11 give: A on both; B on rising and A on falling; A on rising and B on falling; B on both.
- R5: `cfg_mode` bit 1 routes the rising path to out_a and bit 0 routes the falling path to out_b. A cleared bit routes that output's own raw input. Codes are 00 bypass, 01 falling delay only, 10 rising delay only, 11 both.
- R6: In bypass (`cfg_mode` = 00), out_a and out_b equal in_a and in_b from one cycle earlier.
- R7: `cfg_pol` bit 0 inverts the rising-path signal and bit 1 inverts the falling-path signal, only where that path drives an output.
- R8: Each delay ranges from 0 to 2^CNT_W-1 cycles; with the default CNT_W = 10 the range is 0 to 1023.
- R9: Reset is synchronous and active high. During and right after reset with low inputs, every internal register is 0, so out_a = `cfg_mode[1] & cfg_pol[0]` and out_b = `cfg_mode[0] & cfg_pol[1]`.
- R10: A delay of 0 passes edges with only the single register cycle of latency, the same as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | PWM input A |
| in_b | input | 1 | PWM input B |
| dly_rise | input | CNT_W | Rising-edge delay in cycles |
| dly_fall | input | CNT_W | Falling-edge delay in cycles |
| cfg_src | input | 2 | Path source select |
| cfg_mode | input | 2 | Output mode |
| cfg_pol | input | 2 | Per-path inversion |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
The main instance is built with CNT_W = 4, so every delay value fits in a few cycles. This lets one sweep cover all 64 combinations of source, mode and polarity, each with several delay pairs (including 0 and the full-scale 15), under input runs both shorter and longer than the delays. A second instance keeps the default CNT_W = 10 so the full-scale 1023-cycle delay can be timed to the exact cycle on both paths.

// File: rtl/pwm_deadband_pkg.sv
package pwm_deadband_pkg;
   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

   localparam int SRC_RED_BIT  = 0;
   localparam int SRC_FED_BIT  = 1;
   localparam int MODE_FED_BIT = 0;
   localparam int MODE_RED_BIT = 1;
   localparam int POL_RED_BIT  = 0;
   localparam int POL_FED_BIT  = 1;
   localparam int NUM_PATHS    = 2;
endpackage

// File: rtl/pwm_deadband_delay.sv
module pwm_deadband_delay
   import pwm_deadband_pkg::*;
#(
   parameter int         CNT_W = 10,
   parameter edge_kind_e KIND  = EDGE_RISE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             din,
   input  logic [CNT_W-1:0] dly,
   output logic             qout
);
   localparam logic             ACT_LVL = (KIND == EDGE_RISE) ? 1'b1 : 1'b0;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_width
      $error("pwm_deadband_delay: CNT_W out of range");
   end

   logic             act;
   logic [CNT_W-1:0] cnt;

   assign act = (din == ACT_LVL);

   // run counter: length of the current active run, saturating
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (!act) begin
         cnt <= '0;
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   // delayed level: the inactive edge passes at once, the active edge waits
   always_ff @(posedge clk) begin
      if (rst) begin
         qout <= 1'b0;
      end else if (!act) begin
         qout <= ~ACT_LVL;
      end else if (cnt >= dly) begin
         qout <= ACT_LVL;
      end
   end

   AST_PASS_EDGE: assert property (@(posedge clk) disable iff (rst) !act |=> (qout == ~ACT_LVL)); // R1
   AST_ZERO_DLY: assert property (@(posedge clk) disable iff (rst) (act && dly == '0) |=> (qout == ACT_LVL)); // R10
   AST_FRESH_RUN_WAITS: assert property (@(posedge clk) disable iff (rst) (!act ##1 (act && dly != '0 && $stable(dly))) |=> (qout != ACT_LVL)); // R3
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst) (act && cnt == CNT_MAX) |=> (cnt == CNT_MAX || !$past(act))); // R8

   if (KIND == EDGE_RISE) begin : g_rise_chk
      AST_RISE_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst) $rose(qout) |-> $past(din)); // R1
   end else begin : g_fall_chk
      AST_FALL_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst) $fell(qout) |-> !$past(din)); // R2
   end
endmodule

// File: rtl/pwm_deadband_outmux.sv
module pwm_deadband_outmux
   import pwm_deadband_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       in_a,
   input  logic       in_b,
   input  logic       red_q,
   input  logic       fed_q,
   input  logic [1:0] mode,
   input  logic [1:0] pol,
   output logic       out_a,
   output logic       out_b
);
   logic raw_a;
   logic raw_b;

   // raw inputs registered so bypass matches the delay paths' latency
   always_ff @(posedge clk) begin
      if (rst) begin
         raw_a <= 1'b0;
         raw_b <= 1'b0;
      end else begin
         raw_a <= in_a;
         raw_b <= in_b;
      end
   end

   assign out_a = mode[MODE_RED_BIT] ? (red_q ^ pol[POL_RED_BIT]) : raw_a;
   assign out_b = mode[MODE_FED_BIT] ? (fed_q ^ pol[POL_FED_BIT]) : raw_b;
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
   import pwm_deadband_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_a,
   input  logic             in_b,
   input  logic [CNT_W-1:0] dly_rise,
   input  logic [CNT_W-1:0] dly_fall,
   input  logic [1:0]       cfg_src,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_pol,
   output logic             out_a,
   output logic             out_b
);
   logic [NUM_PATHS-1:0] path_src;
   logic [NUM_PATHS-1:0] path_q;
   logic [CNT_W-1:0]     path_dly [NUM_PATHS];

   assign path_dly[0] = dly_rise;
   assign path_dly[1] = dly_fall;

   for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
      localparam edge_kind_e KIND    = (g == 0) ? EDGE_RISE : EDGE_FALL;
      localparam int         SEL_BIT = (g == 0) ? SRC_RED_BIT : SRC_FED_BIT;

      assign path_src[g] = cfg_src[SEL_BIT] ? in_b : in_a;

      pwm_deadband_delay #(
         .CNT_W (CNT_W),
         .KIND  (KIND)
      ) u_delay (
         .clk  (clk),
         .rst  (rst),
         .din  (path_src[g]),
         .dly  (path_dly[g]),
         .qout (path_q[g])
      );
   end

   pwm_deadband_outmux u_outmux (
      .clk   (clk),
      .rst   (rst),
      .in_a  (in_a),
      .in_b  (in_b),
      .red_q (path_q[0]),
      .fed_q (path_q[1]),
      .mode  (cfg_mode),
      .pol   (cfg_pol),
      .out_a (out_a),
      .out_b (out_b)
   );

   AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst) (cfg_mode == 2'b00) |=> (cfg_mode != 2'b00 || out_a == $past(in_a))); // R6
   AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst) (cfg_mode == 2'b00) |=> (cfg_mode != 2'b00 || out_b == $past(in_b))); // R6
   AST_SRC_A_BOTH: assert property (@(posedge clk) disable iff (rst) (cfg_src == 2'b00 && !in_a && cfg_mode == 2'b11 && cfg_pol == 2'b00) |=> ($stable(cfg_src) && $stable(cfg_mode) && $stable(cfg_pol)) |-> !out_a); // R4
endmodule

// File: tb/pwm_deadband_bench.sv
module pwm_deadband_bench;
   localparam int CLK_P  = 10;
   localparam int W      = 4;
   localparam int WW     = 10;
   localparam int WD_CYC = 200000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_a = 1'b0, in_b = 1'b0;
   logic [W-1:0] dly_rise = '0, dly_fall = '0;
   logic [1:0] cfg_src = '0, cfg_mode = '0, cfg_pol = '0;
   logic out_a, out_b;

   logic w_a = 1'b0, w_b = 1'b0;
   logic [WW-1:0] w_dr = '0, w_df = '0;
   logic w_out_a, w_out_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state (run lengths since reset)
   int r_hi, f_lo;
   bit f_seen;
   logic [15:0] lfsr = 16'hACE1;
   int a_left, b_left;

   always #(CLK_P/2) clk = ~clk;

   pwm_deadband #(.CNT_W(W)) u_pwm_deadband (
      .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
      .dly_rise(dly_rise), .dly_fall(dly_fall),
      .cfg_src(cfg_src), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
      .out_a(out_a), .out_b(out_b));

   pwm_deadband #(.CNT_W(WW)) u_pwm_deadband_wide (
      .clk(clk), .rst(rst), .in_a(w_a), .in_b(w_b),
      .dly_rise(w_dr), .dly_fall(w_df),
      .cfg_src(2'b00), .cfg_mode(2'b11), .cfg_pol(2'b00),
      .out_a(w_out_a), .out_b(w_out_b));

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s t=%0t actual=%0b expected=%0b src=%0d mode=%0d pol=%0d dr=%0d df=%0d",
                  tag, $time, act, exp, cfg_src, cfg_mode, cfg_pol, dly_rise, dly_fall);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_a = 1'b0; in_b = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check("R9 reset out_a", out_a, cfg_mode[1] & cfg_pol[0]);
      check("R9 reset out_b", out_b, cfg_mode[0] & cfg_pol[1]);
      @(negedge clk);
      rst = 1'b0;
      r_hi = 0; f_lo = 0; f_seen = 1'b0;
   endtask

   // one cycle: apply inputs at negedge, compare one register later
   task automatic step(input logic a, input logic b, input string tag_a, input string tag_b);
      logic rs, fs, e_red, e_fed, exp_a, exp_b;
      @(negedge clk);
      in_a = a; in_b = b;
      @(posedge clk); #1;
      rs = cfg_src[0] ? b : a;   // R4
      fs = cfg_src[1] ? b : a;
      r_hi = rs ? r_hi + 1 : 0;
      f_lo = fs ? 0 : f_lo + 1;
      if (fs) f_seen = 1'b1;
      e_red = rs && (r_hi - 1 >= int'(dly_rise));
      e_fed = fs || (f_seen && (f_lo - 1 < int'(dly_fall)));
      exp_a = cfg_mode[1] ? (e_red ^ cfg_pol[0]) : a;
      exp_b = cfg_mode[0] ? (e_fed ^ cfg_pol[1]) : b;
      check(tag_a, out_a, exp_a);
      check(tag_b, out_b, exp_b);
   endtask

   function automatic int next_len();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr[4:0]) % 20 + 1;
   endfunction

   initial begin
      #(CLK_P * WD_CYC);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic a_lvl, b_lvl;
      string ta, tb;

      // sweep all source/mode/polarity codes with several delay pairs
      for (int cfg = 0; cfg < 64; cfg++) begin
         for (int dp = 0; dp < 3; dp++) begin
            cfg_src  = cfg[1:0];
            cfg_mode = cfg[3:2];
            cfg_pol  = cfg[5:4];
            dly_rise = (dp == 0) ? 4'd0 : (dp == 1) ? 4'd4 : 4'd15;
            dly_fall = (dp == 0) ? 4'd0 : (dp == 1) ? 4'd9 : 4'd2;
            ta = cfg_mode[1] ? ((dp == 0) ? "R10 R1 R4 R5 R7 out_a" : "R1 R3 R4 R5 R7 R8 out_a") : "R5 R6 out_a";
            tb = cfg_mode[0] ? ((dp == 0) ? "R10 R2 R4 R5 R7 out_b" : "R2 R3 R4 R5 R7 R8 out_b") : "R5 R6 out_b";
            do_reset();
            a_lvl = 1'b0; b_lvl = 1'b0;
            a_left = next_len(); b_left = next_len();
            for (int c = 0; c < 80; c++) begin
               if (a_left == 0) begin a_lvl = ~a_lvl; a_left = next_len(); end
               if (b_left == 0) begin b_lvl = ~b_lvl; b_left = next_len(); end
               a_left--; b_left--;
               step(a_lvl, b_lvl, ta, tb);
            end
         end
      end

      // R3 directed: pulses shorter than the delay vanish
      cfg_src = 2'b00; cfg_mode = 2'b11; cfg_pol = 2'b00;
      dly_rise = 4'd6; dly_fall = 4'd6;
      do_reset();
      for (int c = 0; c < 3; c++) step(1'b1, 1'b0, "R3 short high", "R3 b");
      for (int c = 0; c < 10; c++) begin
         step(1'b0, 1'b0, "R3 short high", "R3 b");
         check("R3 no pulse on out_a", out_a, 1'b0);
      end
      for (int c = 0; c < 12; c++) step(1'b1, 1'b0, "R3 long high", "R3 b");
      for (int c = 0; c < 3; c++) begin
         step(1'b0, 1'b0, "R3 short low", "R3 short low");
         check("R3 no gap on out_b", out_b, 1'b1);
      end
      for (int c = 0; c < 10; c++) step(1'b1, 1'b0, "R3 a", "R3 b");

      // R8 full-scale delay on the default-width instance
      w_dr = 10'd1023; w_df = 10'd1023;
      @(negedge clk); w_a = 1'b1;
      for (int k = 0; k < 1024; k++) begin
         @(posedge clk); #1;
         if (k == 1022) check("R8 R1 wide out_a before 1023", w_out_a, 1'b0);
         if (k == 1023) check("R8 R1 wide out_a at 1023", w_out_a, 1'b1);
      end
      @(negedge clk); w_a = 1'b0;
      @(posedge clk); #1;
      check("R1 wide out_a falls at once", w_out_a, 1'b0);
      check("R2 wide out_b still high", w_out_b, 1'b1);
      for (int k = 1; k < 1024; k++) begin
         @(posedge clk); #1;
         if (k == 1022) check("R8 R2 wide out_b before 1023", w_out_b, 1'b1);
         if (k == 1023) check("R8 R2 wide out_b at 1023", w_out_b, 1'b0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule